// File: doc/BRIEF.md
# Programmable Baud Clock Generator

This block produces the timing enables that drive UART receivers and transmitters. A selectable front end picks one of six fixed prescalings of the system clock (divide by 1, 2, 6, 32, 64 or 128), or it picks the rising edges of an external clock pin. A 16-bit divisor then divides the chosen stream of enables. The result is a one-cycle 16x oversampling enable. A further fixed divide-by-16 turns it into a one-cycle per-bit enable. Every consumer treats the 16x enable as an oversampling clock.

Software sets the generator up through a byte-wide register port. A control register holds a run bit and the source code. Two further registers hold the upper and lower divisor bytes. While the run bit is 0, the whole counting chain is held cleared. When the run bit is set, counting restarts from the programmed divisor.

Register map: address 0 is the control register, address 1 is the divisor upper byte, address 2 is the divisor lower byte. Address 3 is unused.

Top module: `bclk_gen`

## Requirements
- R1: After reset all three registers read 0, and both `tick16_o` and `bit_tick_o` are low.
- R2: Each register at addresses 0, 1 and 2 reads back the full byte last written to it. Read data appears one clock after the address is applied.
- R3: While control bit 7 (run) is 0, no enable of either kind is produced, and the divide chain is held at its start point.
- R4: With control bits 6:4 set to a code from 0 to 5 (divide by 1, 2, 6, 32, 64, 128) and divisor N, consecutive `tick16_o` pulses are exactly ratio×N system clocks apart.
- R5: With source code 6, each rising edge of `ext_clk` produces one prescaled enable after a two-flop synchronizer. A steady external period of P clocks therefore spaces `tick16_o` by P×N.
- R6: Source code 7 yields no prescaled enables, so `tick16_o` stays low while the run bit is set.
- R7: A divisor of 0 acts as 65536. A divisor of 1 passes every prescaled enable through as a `tick16_o` pulse.
- R8: A divisor written while the generator runs leaves the interval in progress unchanged and takes effect from the next terminal count.
- R9: When the run bit goes from 0 to 1, counting restarts from the divisor. The delay from start to the first `tick16_o` therefore grows by exactly ratio clocks per unit of divisor.
- R10: `bit_tick_o` pulses together with every 16th `tick16_o` pulse and at no other time, counted from the start of a run.
- R11: Writes to address 3 change no register, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| ext_clk | input | 1 | External clock source, asynchronous |
| tick16_o | output | 1 | One-cycle 16x oversampling enable |
| bit_tick_o | output | 1 | One-cycle per-bit enable |

## Verification
Read data is due one clock after the address. The bench sets the address just after a falling edge and samples it at the next falling edge. The enables come out of the prescaler and divider registers with a fixed pipeline delay. To stay clear of that delay, the bench measures the distance between successive pulses, which is fixed by ratio×N alone. The start delay is compared only as a difference between two divisors (R9, R7). A divisor change is checked on the first two intervals after a write made just after a pulse. Those intervals must come out as the old value and then the new one.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

  typedef enum logic [2:0] {
    SRC_DIV1   = 3'd0,
    SRC_DIV2   = 3'd1,
    SRC_DIV6   = 3'd2,
    SRC_DIV32  = 3'd3,
    SRC_DIV64  = 3'd4,
    SRC_DIV128 = 3'd5,
    SRC_EXT    = 3'd6,
    SRC_OFF    = 3'd7
  } src_sel_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIVH = 2'd1;
  localparam logic [1:0] ADDR_DIVL = 2'd2;

  // prescale ratio for the internal sources, 0 for the non-counting ones
  function automatic int unsigned src_ratio(src_sel_e s);
    case (s)
      SRC_DIV1:   return 1;
      SRC_DIV2:   return 2;
      SRC_DIV6:   return 6;
      SRC_DIV32:  return 32;
      SRC_DIV64:  return 64;
      SRC_DIV128: return 128;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/bclk_regs.sv
module bclk_regs
  import bclk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              run,
  output src_sel_e          sel,
  output logic [DIV_W-1:0]  divisor
);

  localparam int RUN_BIT = DATA_W - 1;
  localparam int SEL_HI  = DATA_W - 2;

  logic [DATA_W-1:0] ctrl_q, divh_q, divl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      divh_q <= '0;
      divl_q <= '0;
    end else if (wr) begin
      case (addr)
        ADDR_W'(ADDR_CTRL): ctrl_q <= wdata;
        ADDR_W'(ADDR_DIVH): divh_q <= wdata;
        ADDR_W'(ADDR_DIVL): divl_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_W'(ADDR_CTRL): rdata <= ctrl_q;
        ADDR_W'(ADDR_DIVH): rdata <= divh_q;
        ADDR_W'(ADDR_DIVL): rdata <= divl_q;
        default:            rdata <= '0;
      endcase
    end
  end

  assign run     = ctrl_q[RUN_BIT];
  assign sel     = src_sel_e'(ctrl_q[SEL_HI -: 3]);
  assign divisor = {divh_q, divl_q};

  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADDR_W'(ADDR_CTRL)) |=> (ctrl_q == $past(wdata)));

  assert_div_write_R2: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADDR_W'(ADDR_DIVL)) |=> (divl_q == $past(wdata)));

  assert_unused_addr_R11: assert property (@(posedge clk) disable iff (rst)
    (wr && addr == ADDR_W'(3)) |=> ($stable(ctrl_q) && $stable(divh_q) && $stable(divl_q)));

endmodule

// File: rtl/bclk_prescale.sv
module bclk_prescale
  import bclk_pkg::*;
#(
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     run,
  input  src_sel_e sel,
  input  logic     ext_in,
  output logic     pre_en
);

  // synchronizer plus one edge-detect flop
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise;
  logic [PS_W-1:0]      pcnt_q;
  logic [PS_W-1:0]      limit;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-1:0], ext_in};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign limit    = PS_W'(src_ratio(sel) - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt_q <= '0;
      pre_en <= 1'b0;
    end else begin
      case (sel)
        SRC_EXT: begin
          pcnt_q <= '0;
          pre_en <= ext_rise;
        end
        SRC_OFF: begin
          pcnt_q <= '0;
          pre_en <= 1'b0;
        end
        default: begin
          if (pcnt_q >= limit) begin
            pcnt_q <= '0;
            pre_en <= 1'b1;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
            pre_en <= 1'b0;
          end
        end
      endcase
    end
  end

  assert_stopped_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pre_en);

  assert_off_source_R6: assert property (@(posedge clk) disable iff (rst)
    (run && sel == SRC_OFF) |=> !pre_en);

  assert_div1_every_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (run && sel == SRC_DIV1) |=> pre_en);

  assert_ext_edge_R5: assert property (@(posedge clk) disable iff (rst)
    (run && sel == SRC_EXT && pre_en) |-> $past(sync_q[SYNC_STAGES-1]));

endmodule

// File: rtl/bclk_divider.sv
module bclk_divider #(
  parameter int DIV_W = 16,
  parameter int OS    = 16,
  localparam int OS_W = $clog2(OS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_en,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick16,
  output logic             bit_tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [OS_W-1:0]  bcnt_q;
  logic             hit;

  // count down to 1; a zero load wraps through the full range
  assign hit = run && pre_en && (cnt_q == DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      bcnt_q   <= '0;
      tick16   <= 1'b0;
      bit_tick <= 1'b0;
    end else if (!run) begin
      cnt_q    <= divisor;
      bcnt_q   <= '0;
      tick16   <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      tick16   <= hit;
      bit_tick <= hit && (bcnt_q == OS_W'(OS - 1));
      if (pre_en) cnt_q <= (cnt_q == DIV_W'(1)) ? divisor : cnt_q - 1'b1;
      if (hit)    bcnt_q <= bcnt_q + 1'b1;
    end
  end

  assert_stop_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!tick16 && !bit_tick));

  assert_tick_needs_pre_R4: assert property (@(posedge clk) disable iff (rst)
    tick16 |-> $past(pre_en));

  assert_bit_with_tick_R10: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> tick16);

endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
  import bclk_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OS          = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ext_clk,
  output logic              tick16_o,
  output logic              bit_tick_o
);

  localparam int DIV_W = 2 * DATA_W;

  logic             run;
  src_sel_e         sel;
  logic [DIV_W-1:0] divisor;
  logic             pre_en;

  bclk_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
    .rdata(reg_rdata), .run(run), .sel(sel), .divisor(divisor)
  );

  bclk_prescale #(.PS_W(PS_W), .SYNC_STAGES(SYNC_STAGES)) pre_i (
    .clk(clk), .rst(rst), .run(run), .sel(sel), .ext_in(ext_clk), .pre_en(pre_en)
  );

  bclk_divider #(.DIV_W(DIV_W), .OS(OS)) div_i (
    .clk(clk), .rst(rst), .run(run), .pre_en(pre_en), .divisor(divisor),
    .tick16(tick16_o), .bit_tick(bit_tick_o)
  );

endmodule

// File: tb/bclk_gen_tb_top.sv
`timescale 1ns/1ps
module bclk_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_clk = 1'b0;
  logic       tick16_o, bit_tick_o;
  logic       ext_on = 1'b0;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bclk_gen dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_clk(ext_clk),
    .tick16_o(tick16_o), .bit_tick_o(bit_tick_o)
  );

  function automatic int ratio_of(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 6;
      3: return 32;
      4: return 64;
      5: return 128;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_space(int code, int div, int ext_period);
    int n = (div == 0) ? 65536 : div;
    return (code == 6) ? ext_period * n : ratio_of(code) * n;
  endfunction

  task automatic check_eq(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_tick(output int t);
    do @(negedge clk); while (!tick16_o);
    t = cyc;
  endtask

  // stop, load divisor, start with the given source; returns start cycle
  task automatic start(int code, int div, output int t_start);
    wr(2'd0, 8'h00);
    wr(2'd1, div[15:8]);
    wr(2'd2, div[7:0]);
    wr(2'd0, {1'b1, code[2:0], 4'h0});
    t_start = cyc;
  endtask

  task automatic measure(int code, int div, string req);
    int ts, t0, t1, t2;
    start(code, div, ts);
    wait_tick(t0);
    wait_tick(t1);
    wait_tick(t2);
    check_eq(t1 - t0, exp_space(code, div, 8), req);
    check_eq(t2 - t1, exp_space(code, div, 8), req);
  endtask

  // external source: period of 8 system clocks
  initial begin
    forever begin
      @(negedge clk);
      if (ext_on) begin
        repeat (3) @(negedge clk);
        ext_clk = ~ext_clk;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int ts, t0, t1, t2, cnt, lat_a, lat_b;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check_eq(int'(tick16_o), 0, "R1 tick16");
    check_eq(int'(bit_tick_o), 0, "R1 bit_tick");
    rd(2'd0, d); check_eq(int'(d), 0, "R1 ctrl");
    rd(2'd1, d); check_eq(int'(d), 0, "R1 divh");
    rd(2'd2, d); check_eq(int'(d), 0, "R1 divl");

    // R2 readback, R11 unused address
    wr(2'd0, 8'h2B); wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    wr(2'd3, 8'hFF);
    rd(2'd0, d); check_eq(int'(d), 'h2B, "R2 ctrl");
    rd(2'd1, d); check_eq(int'(d), 'hA5, "R2 divh R11");
    rd(2'd2, d); check_eq(int'(d), 'h3C, "R2 divl R11");
    rd(2'd3, d); check_eq(int'(d), 0, "R11 read");

    // R4 every internal source, several divisors; R7 divisor 1
    for (int c = 0; c < 6; c++) begin
      measure(c, 1, "R4 R7 div1");
      measure(c, 3, "R4");
    end
    measure(0, 7, "R4");

    // R4 constrained random source and divisor
    for (int i = 0; i < 8; i++) begin
      int c = int'($urandom_range(5, 0));
      int n = int'($urandom_range(12, 1));
      measure(c, n, "R4 random");
    end

    // R5 external source
    ext_on = 1'b1;
    measure(6, 1, "R5");
    measure(6, 3, "R5");
    ext_on = 1'b0;

    // R6 reserved source produces nothing
    start(7, 1, ts);
    cnt = 0;
    repeat (400) begin @(negedge clk); if (tick16_o) cnt++; end
    check_eq(cnt, 0, "R6");

    // R3 stopped: no enables, registers kept
    start(0, 2, ts);
    wait_tick(t0);
    wr(2'd0, 8'h00);
    cnt = 0;
    repeat (400) begin @(negedge clk); if (tick16_o || bit_tick_o) cnt++; end
    check_eq(cnt, 0, "R3");
    rd(2'd2, d); check_eq(int'(d), 2, "R3 divisor kept");

    // R10 bit enable every 16 ticks, coincident
    start(0, 2, ts);
    cnt = 0;
    for (int k = 0; k < 64; k++) begin
      wait_tick(t0);
      if (bit_tick_o) cnt++;
    end
    check_eq(cnt, 4, "R10 count");
    do @(negedge clk); while (!bit_tick_o);
    t1 = cyc;
    check_eq(int'(tick16_o), 1, "R10 coincide");
    do @(negedge clk); while (!bit_tick_o);
    check_eq(cyc - t1, 32, "R10 spacing");

    // R8 divisor change at terminal count
    start(0, 4, ts);
    wait_tick(t0);
    wr(2'd2, 8'd10);
    wait_tick(t1);
    wait_tick(t2);
    check_eq(t1 - t0, 4, "R8 old interval");
    check_eq(t2 - t1, 10, "R8 new interval");

    // R9 restart latency, R7 divisor 0 as 65536
    start(1, 5, ts); wait_tick(t0); lat_a = t0 - ts;
    start(1, 9, ts); wait_tick(t0); lat_b = t0 - ts;
    check_eq(lat_b - lat_a, 2 * 4, "R9");
    start(0, 5, ts); wait_tick(t0); lat_a = t0 - ts;
    start(0, 0, ts); wait_tick(t0); lat_b = t0 - ts;
    check_eq(lat_b - lat_a, 65536 - 5, "R7 div0");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule